// File: doc/BRIEF.md
# Serial-Flash Controller Request Unit

This block gathers the status events of a serial-flash controller and turns them into a small set of interrupt lines and one DMA request line. There are fourteen conditions. Thirteen are sticky event flags: a one-cycle pulse on the matching event input sets the flag, and it stays set until software writes one to its bit. The fourteenth, the receive-drain flag, has no event input. It follows the receive-watermark-exceeded level and is never sticky.

A per-condition enable register gates every flag before it reaches an interrupt line. Transmit-fill, receive-drain and transaction-done each drive a line of their own. The three buffer overflow and underrun conditions share one fault line. The eight command and access errors share one error line. The receive-drain condition also has a second, separate enable for DMA. While that enable is set, every write into the receive buffer produces exactly one DMA request pulse. This does not depend on the flag level.

Software reaches the flags and enables through a simple register port. Writes are one cycle and reads are combinational. The protocol engine and the buffers lie outside this block.

Top module: `sfc_req_unit`

## Requirements
- R1: After reset all flags, all enable bits, every IRQ output and dma_req_o are 0.
- R2: A pulse on evt_i[k] (k = 0..12) sets flag k at that clock edge. The flag reads back as bit k at register address 0 and stays set, whatever evt_i does afterwards, until it is cleared.
- R3: A write to address 0 clears every sticky flag whose data bit is 1 and leaves the flags written with 0 unchanged. Bit 13, the receive-drain flag, is not affected by such a write.
- R4: If an event pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R5: Flag bit 13 (receive drain) equals rx_wm_i as sampled at the previous clock edge.
- R6: irq_tx_fill_o is 1 exactly when flag 0 and enable bit 0 were both set one cycle earlier. It is a registered level.
- R7: irq_rx_drain_o follows flag 13 gated by enable bit 13, one cycle later. Enable bit 14 (DMA) has no effect on it, and enable bit 13 has no effect on dma_req_o.
- R8: irq_fault_o is the OR of flags 1, 2 and 3 (TX underrun, RX overflow, system-bus buffer overflow), each gated by its own enable bit, registered one cycle.
- R9: irq_err_o is the OR of flags 4 to 11 (the command and access errors), each gated by its own enable bit, registered one cycle.
- R10: irq_done_o is flag 12 (transaction finished) gated by enable bit 12, registered one cycle.
- R11: dma_req_o is high for exactly one cycle after each cycle in which rx_wr_i is 1 while enable bit 14 is 1. Back-to-back writes give back-to-back pulses. With enable bit 14 at 0 there is no pulse.
- R12: Address 1 holds the 15 enable bits and reads them back. Address 0 reads the 14 flags in bits 13:0 with bit 14 at 0. Addresses 2 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 13 | One-cycle event pulses for sticky flags 0..12 |
| rx_wm_i | input | 1 | Receive watermark exceeded level |
| rx_wr_i | input | 1 | Strobe, one per receive-buffer write |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 2 | Register write address |
| reg_wdata_i | input | 15 | Register write data |
| reg_raddr_i | input | 2 | Register read address |
| reg_rdata_o | output | 15 | Register read data, combinational |
| irq_tx_fill_o | output | 1 | Transmit-fill interrupt |
| irq_rx_drain_o | output | 1 | Receive-drain interrupt |
| irq_fault_o | output | 1 | Shared overflow/underrun interrupt |
| irq_err_o | output | 1 | Shared command/access error interrupt |
| irq_done_o | output | 1 | Transaction-finished interrupt |
| dma_req_o | output | 1 | Receive-drain DMA request pulse |

## Verification
A flag that is lost or wrongly held shows on the flag read-back in the cycle right after the edge that should have changed it. It reaches the interrupt line one cycle later. A wrong enable bit or a wrong group mask shows up only when some flag in that group is set, so each line is driven by one of its members with its own enable on and then off. A DMA path that followed the flag level, or that ignored its enable, shows as a missing, extra or stretched pulse one cycle after a receive-buffer write.

// File: rtl/sfc_req_pkg.sv
package sfc_req_pkg;
  localparam int unsigned NUM_EVT  = 13;
  localparam int unsigned NUM_FLAG = NUM_EVT + 1;
  localparam int unsigned DATA_W   = NUM_FLAG + 1;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned NUM_IRQ  = 5;

  // flag positions
  localparam int unsigned F_TX_FILL  = 0;
  localparam int unsigned F_DONE     = 12;
  localparam int unsigned F_RX_DRAIN = 13;
  localparam int unsigned EN_DMA     = 14;

  typedef enum int unsigned {
    IRQ_TX_FILL  = 0,
    IRQ_RX_DRAIN = 1,
    IRQ_FAULT    = 2,
    IRQ_ERR      = 3,
    IRQ_DONE     = 4
  } irq_line_e;

  // group masks, group 0 in the low bits
  localparam logic [NUM_FLAG*NUM_IRQ-1:0] GROUP_MASKS = {
    14'h1000,  // done
    14'h0FF0,  // command/access errors
    14'h000E,  // overflow/underrun
    14'h2000,  // rx drain
    14'h0001   // tx fill
  };
endpackage

// File: rtl/sfc_flag_bank.sv
module sfc_flag_bank #(
  parameter int unsigned N_EVT = 13,
  localparam int unsigned N_FLAG = N_EVT + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EVT-1:0]  set_i,
  input  logic [N_EVT-1:0]  clr_i,
  input  logic              lvl_i,
  output logic [N_FLAG-1:0] flags_o
);
  logic [N_EVT-1:0] sticky_q;
  logic             lvl_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= '0;
    else         sticky_q <= set_i | (sticky_q & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign flags_o = {lvl_q, sticky_q};
endmodule

// File: rtl/sfc_req_regs.sv
module sfc_req_regs #(
  parameter int unsigned N_EVT  = 13,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned N_FLAG = N_EVT + 1,
  localparam int unsigned DATA_W = N_FLAG + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  input  logic [N_FLAG-1:0] flags_i,
  output logic [DATA_W-1:0] en_o,
  output logic [N_EVT-1:0]  clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] ADDR_FLAG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_EN   = ADDR_W'(1);

  logic [DATA_W-1:0] en_q;
  logic              wr_flag, wr_en;

  assign wr_flag = we_i && (waddr_i == ADDR_FLAG);
  assign wr_en   = we_i && (waddr_i == ADDR_EN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (wr_en) en_q <= wdata_i;
  end

  assign clr_o = wr_flag ? wdata_i[N_EVT-1:0] : '0;
  assign en_o  = en_q;

  always_comb begin
    case (raddr_i)
      ADDR_FLAG: rdata_o = DATA_W'(flags_i);
      ADDR_EN:   rdata_o = en_q;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sfc_irq_merge.sv
module sfc_irq_merge #(
  parameter int unsigned N = 14,
  parameter int unsigned G = 5,
  parameter logic [N*G-1:0] MASKS = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  output logic [G-1:0] irq_o
);
  logic [N-1:0] live;
  assign live = flags_i & en_i;

  for (genvar g = 0; g < G; g++) begin : g_line
    logic line_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) line_q <= 1'b0;
      else         line_q <= |(live & MASKS[g*N +: N]);
    end
    assign irq_o[g] = line_q;
  end
endmodule

// File: rtl/sfc_dma_pulse.sv
module sfc_dma_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic en_i,
  output logic req_o
);
  logic req_q;
  // one pulse per buffer write, independent of flag level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= wr_i & en_i;
  end
  assign req_o = req_q;
endmodule

// File: rtl/sfc_req_unit.sv
module sfc_req_unit
  import sfc_req_pkg::*;
#(
  parameter int unsigned N_EVT = NUM_EVT,
  localparam int unsigned N_FLAG = N_EVT + 1,
  localparam int unsigned DW     = N_FLAG + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              rx_wm_i,
  input  logic              rx_wr_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_waddr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  logic [ADDR_W-1:0] reg_raddr_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_tx_fill_o,
  output logic              irq_rx_drain_o,
  output logic              irq_fault_o,
  output logic              irq_err_o,
  output logic              irq_done_o,
  output logic              dma_req_o
);
  logic [N_FLAG-1:0]  flags_w;
  logic [DW-1:0]      en_w;
  logic [N_EVT-1:0]   clr_w;
  logic [NUM_IRQ-1:0] irq_w;

  sfc_flag_bank #(.N_EVT(N_EVT)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (evt_i),
    .clr_i   (clr_w),
    .lvl_i   (rx_wm_i),
    .flags_o (flags_w)
  );

  sfc_req_regs #(.N_EVT(N_EVT), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .waddr_i (reg_waddr_i),
    .wdata_i (reg_wdata_i),
    .raddr_i (reg_raddr_i),
    .flags_i (flags_w),
    .en_o    (en_w),
    .clr_o   (clr_w),
    .rdata_o (reg_rdata_o)
  );

  sfc_irq_merge #(.N(N_FLAG), .G(NUM_IRQ), .MASKS(GROUP_MASKS)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flags_i (flags_w),
    .en_i    (en_w[N_FLAG-1:0]),
    .irq_o   (irq_w)
  );

  sfc_dma_pulse u_dma (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (rx_wr_i),
    .en_i   (en_w[DW-1]),
    .req_o  (dma_req_o)
  );

  assign irq_tx_fill_o  = irq_w[IRQ_TX_FILL];
  assign irq_rx_drain_o = irq_w[IRQ_RX_DRAIN];
  assign irq_fault_o    = irq_w[IRQ_FAULT];
  assign irq_err_o      = irq_w[IRQ_ERR];
  assign irq_done_o     = irq_w[IRQ_DONE];
endmodule

// File: rtl/sfc_req_chk.sv
module sfc_req_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [12:0] evt_i,
  input logic        rx_wm_i,
  input logic        rx_wr_i,
  input logic        reg_we_i,
  input logic [1:0]  reg_waddr_i,
  input logic [13:0] flags,
  input logic [14:0] en,
  input logic        irq_done_o,
  input logic        dma_req_o
);
  // R2: sticky flags never drop without a clear write
  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_waddr_i == 2'd0) |=>
      ((flags[12:0] & $past(flags[12:0])) == $past(flags[12:0])));

  // R4: an event always lands, clear or not
  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flags[12:0] & $past(evt_i)) == $past(evt_i)));

  // R5
  a_r5_rx_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (flags[13] == $past(rx_wm_i)));

  // R10
  a_r10_done_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_done_o |-> $past(flags[12] && en[12]));

  // R11
  a_r11_dma_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_wr_i && en[14]) |=> dma_req_o);

  a_r11_dma_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_wr_i && en[14]) |=> !dma_req_o);
endmodule

bind sfc_req_unit sfc_req_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_i       (evt_i),
  .rx_wm_i     (rx_wm_i),
  .rx_wr_i     (rx_wr_i),
  .reg_we_i    (reg_we_i),
  .reg_waddr_i (reg_waddr_i),
  .flags       (flags_w),
  .en          (en_w),
  .irq_done_o  (irq_done_o),
  .dma_req_o   (dma_req_o)
);

// File: tb/sfc_req_unit_tb.sv
module sfc_req_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] evt = '0;
  logic        rx_wm = 1'b0, rx_wr = 1'b0, we = 1'b0;
  logic [1:0]  waddr = '0, raddr = '0;
  logic [14:0] wdata = '0, rdata;
  logic        irq_txf, irq_rxd, irq_flt, irq_err, irq_dn, dma;
  logic [4:0]  irq_v;

  always #2 clk = ~clk;

  sfc_req_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .rx_wm_i(rx_wm), .rx_wr_i(rx_wr),
    .reg_we_i(we), .reg_waddr_i(waddr), .reg_wdata_i(wdata), .reg_raddr_i(raddr),
    .reg_rdata_o(rdata), .irq_tx_fill_o(irq_txf), .irq_rx_drain_o(irq_rxd),
    .irq_fault_o(irq_flt), .irq_err_o(irq_err), .irq_done_o(irq_dn), .dma_req_o(dma)
  );

  assign irq_v = {irq_dn, irq_err, irq_flt, irq_rxd, irq_txf};

  typedef struct {string tag; int sel; logic [15:0] exp;} item_t;
  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done_f = 1'b0;
  logic [15:0] act;

  // monitor: sel 0 = read data, 1 = irq vector {done,err,fault,rxd,txf}, 2 = dma
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      act = (it.sel == 0) ? {1'b0, rdata} : (it.sel == 1) ? {11'b0, irq_v} : {15'b0, dma};
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic push(string tag, int sel, logic [15:0] e);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = e;
    q.push_back(it);
  endtask
  task automatic sync();
    @(negedge clk); #1;
  endtask
  task automatic wr(logic [1:0] a, logic [14:0] d);
    we = 1'b1; waddr = a; wdata = d;
    step();
    we = 1'b0;
  endtask
  task automatic pulse(logic [12:0] m);
    evt = m;
    step();
    evt = '0;
  endtask
  task automatic clear_all();
    wr(2'd0, 15'h7FFF); wr(2'd1, 15'h0000); step(2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    raddr = 2'd0;
    push("R1 flags", 0, 16'h0); push("R1 irq", 1, 16'h0); push("R1 dma", 2, 16'h0); sync();
    raddr = 2'd1; push("R1 enables", 0, 16'h0); sync();

    // R12 register map
    wr(2'd1, 15'h7FFF); push("R12 en all", 0, 16'h7FFF); push("R12 no flags no irq", 1, 16'h0); sync();
    wr(2'd1, 15'h1234); push("R12 en pattern", 0, 16'h1234); sync();
    raddr = 2'd2; push("R12 addr2", 0, 16'h0); sync();
    raddr = 2'd3; push("R12 addr3", 0, 16'h0); sync();
    wr(2'd1, 15'h0000); raddr = 2'd0;

    // R2 / R6 tx fill
    wr(2'd1, 15'h0001);
    pulse(13'h0001);
    push("R2 flag set", 0, 16'h0001); push("R6 one cycle later", 1, 16'h00); sync();
    step(); push("R6 irq up", 1, 16'h01); sync();
    step(5); push("R2 sticky", 0, 16'h0001); push("R6 held", 1, 16'h01); sync();

    // R3 write-one-to-clear
    wr(2'd0, 15'h7FFE); push("R3 zero bit keeps", 0, 16'h0001); sync();
    wr(2'd0, 15'h0001); push("R3 cleared", 0, 16'h0000); push("R6 registered", 1, 16'h01); sync();
    step(); push("R3 irq drops", 1, 16'h00); sync();

    // R6 gating
    wr(2'd1, 15'h0000); pulse(13'h0001); step();
    push("R6 gated flag", 0, 16'h0001); push("R6 gated off", 1, 16'h00); sync();
    wr(2'd1, 15'h0001); step(); push("R6 enable late", 1, 16'h01); sync();
    clear_all();

    // R4 set wins
    evt = 13'h0001; we = 1'b1; waddr = 2'd0; wdata = 15'h0001;
    step(); evt = '0; we = 1'b0;
    push("R4 set wins", 0, 16'h0001); sync();
    wr(2'd0, 15'h0001); push("R3 clear after", 0, 16'h0000); sync();

    // R5 / R7 rx drain
    wr(2'd1, 15'h2000);
    pulse(13'h0000);
    rx_wm = 1'b1; step();
    push("R5 follows level", 0, 16'h2000); push("R7 not yet", 1, 16'h00); sync();
    step(); push("R7 irq up", 1, 16'h02); push("R7 no dma", 2, 16'h0); sync();
    wr(2'd0, 15'h2000); push("R3 rx bit untouched", 0, 16'h2000); sync();
    rx_wm = 1'b0; step(); push("R5 falls", 0, 16'h0000); sync();
    step(); push("R7 irq falls", 1, 16'h00); sync();
    wr(2'd1, 15'h4000); rx_wm = 1'b1; step(2);
    push("R7 dma en no irq", 1, 16'h00); push("R5 level", 0, 16'h2000); sync();
    rx_wm = 1'b0; step(2);

    // R11 dma
    rx_wr = 1'b1; step(); rx_wr = 1'b0;
    push("R11 pulse", 2, 16'h1); sync();
    step(); push("R11 single", 2, 16'h0); sync();
    rx_wr = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(); push("R11 burst", 2, 16'h1); sync();
    end
    rx_wr = 1'b0; step(); push("R11 burst end", 2, 16'h0); sync();
    wr(2'd1, 15'h2000); rx_wr = 1'b1; step(); rx_wr = 1'b0;
    push("R7 irq en no dma", 2, 16'h0); sync();
    wr(2'd1, 15'h0000); rx_wr = 1'b1; step(); rx_wr = 1'b0;
    push("R11 disabled", 2, 16'h0); sync();

    // R8 fault group
    wr(2'd1, 15'h000E); pulse(13'h0004); step();
    push("R8 rx overflow", 1, 16'h04); sync();
    wr(2'd0, 15'h0004); step(); push("R8 cleared", 1, 16'h00); sync();
    wr(2'd1, 15'h0006); pulse(13'h0008); step();
    push("R8 gated flag", 0, 16'h0008); push("R8 gated off", 1, 16'h00); sync();
    wr(2'd1, 15'h000E); step(); push("R8 bus ovf", 1, 16'h04); sync();
    clear_all();
    wr(2'd1, 15'h000E); pulse(13'h0002); step(); push("R8 tx underrun", 1, 16'h04); sync();
    clear_all();

    // R9 error group
    wr(2'd1, 15'h0800); pulse(13'h0010); step();
    push("R9 gated flag", 0, 16'h0010); push("R9 gated off", 1, 16'h00); sync();
    pulse(13'h0800); step(); push("R9 err up", 1, 16'h08); sync();
    clear_all();

    // R10 done
    wr(2'd1, 15'h1000); pulse(13'h1000); step();
    push("R10 done up", 1, 16'h10); sync();
    wr(2'd0, 15'h1000); step(); push("R10 done down", 1, 16'h00); sync();

    // R2 all events at once
    wr(2'd1, 15'h7FFF); pulse(13'h1FFF);
    push("R2 all set", 0, 16'h1FFF); sync();
    step(); push("R2 all irq", 1, 16'h1D); sync();
    clear_all(); push("R3 all cleared", 0, 16'h0000); push("R1 quiet", 1, 16'h00); sync();

    done_f = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_f) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule